// File: doc/BRIEF.md
# Trigger Dispatcher with Per-Channel Overrun Flags

This block accepts trigger events from a small number of event sources and routes each one to one of four generator channels: an ADC command generator (channel 0), a first timer trigger generator (channel 1), a second timer trigger generator (channel 2) and an external trigger generator (channel 3). Each source presents a one-cycle strobe together with a channel index. For every event it accepts, the block sends the selected channel a pulse of fixed shape: one cycle high followed by at least one cycle low.

Each generator answers with a ready line. It holds ready low from the moment it takes a pulse until its own output is complete, guard time included. For the ADC channel this means until the last conversion of a batch. Busy state is kept separately for each channel. A request to a busy channel is dropped and sets that channel's sticky overrun flag, while requests to idle channels in the same or later cycles go ahead untouched. Software clears the flags with a write-one-to-clear strobe.

Top module: `trig_dispatch`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every trigger output and every overrun flag is 0.
- R2: An accepted event drives the selected channel's bit of `trig_o` high for exactly one cycle, in the cycle after the strobe is sampled, and then low for at least one cycle. Source s selects its channel with `evt_sel_i[2s+1:2s]`, and channel index c is bit c of `trig_o`, `gen_rdy_i`, `ovr_o` and `clr_mask_i`.
- R3: A pulse goes out only when the channel's own pulse shaper is idle and its `gen_rdy_i` bit is high in the cycle the strobe is sampled.
- R4: An event aimed at a channel whose ready is low produces no pulse, and it sets that channel's overrun flag, visible in the next cycle.
- R5: An event aimed at a channel in the two cycles after that channel accepted an event is dropped and sets its overrun flag, even if its ready is still high.
- R6: A busy channel blocks only requests to itself. An event to an idle, ready channel is accepted while any other channel is busy, and it leaves the other channels' flags unchanged.
- R7: Events from different sources in the same cycle are handled independently. If they target different channels, both pulses appear in the same cycle. If they target the same channel, they merge into a single request: one pulse and no overrun.
- R8: Overrun flags are sticky. Flag c clears only when `clr_we_i` is high with `clr_mask_i[c]` set. Mask bits without `clr_we_i`, and mask bits of other channels, leave it unchanged.
- R9: If a flag is set and cleared in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_stb_i | input | NUM_SRC (2) | One-cycle event strobe per source |
| evt_sel_i | input | NUM_SRC*SEL_W (4) | Target channel index per source, packed |
| gen_rdy_i | input | NUM_CH (4) | Ready line returned by each generator |
| clr_we_i | input | 1 | Write strobe for flag clearing |
| clr_mask_i | input | NUM_CH (4) | Write-one-to-clear mask for the overrun flags |
| trig_o | output | NUM_CH (4) | Trigger pulse to each generator |
| ovr_o | output | NUM_CH (4) | Sticky overrun flag per channel |

## Verification
Two functions can land in the same cycle. A dropped request can set a flag in the same cycle that a clear write targets it. Two sources can also fire in one cycle, either at different channels or at the same one. The bench provokes the first case by holding the external generator busy and driving its event together with a clear of bit 3. The flag must still read as set in the next cycle. It then drives both sources together at different channels, at the same channel, and at one busy and one idle channel. Each result is judged from the `trig_o` and `ovr_o` values one cycle after the strobe.

// File: rtl/trig_dispatch_pkg.sv
package trig_dispatch_pkg;

    // Channel roles; the index is the bit position on every per-channel bus.
    localparam int unsigned CH_COUNT = 4;
    localparam int unsigned CH_ADC   = 0;
    localparam int unsigned CH_TMR_A = 1;
    localparam int unsigned CH_TMR_B = 2;
    localparam int unsigned CH_EXT   = 3;

    // Phases of the fixed-shape pulse: idle, high cycle, low cycle.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } pulse_phase_e;

    typedef struct packed {
        pulse_phase_e phase;
        logic         trig;
    } chan_state_t;

endpackage

// File: rtl/trig_evt_route.sv
module trig_evt_route #(
    parameter int NUM_SRC = 2,
    parameter int NUM_CH  = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_SRC-1:0]       evt_stb_i,
    input  logic [NUM_SRC*SEL_W-1:0] evt_sel_i,
    output logic [NUM_CH-1:0]        chan_req_o
);

    // Every channel ORs the strobes of all sources that point at it, so
    // two sources aimed at one channel in the same cycle merge into one request.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        always_comb begin
            chan_req_o[c] = 1'b0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (evt_stb_i[s] && (evt_sel_i[s*SEL_W +: SEL_W] == SEL_W'(c))) begin
                    chan_req_o[c] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/trig_chan_ctrl.sv
module trig_chan_ctrl
    import trig_dispatch_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic rdy_i,
    output logic trig_o,
    output logic ovr_set_o
);

    chan_state_t s_d, s_q;
    logic        ovr_set_d;

    always_comb begin
        s_d       = s_q;
        s_d.trig  = 1'b0;
        ovr_set_d = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                if (req_i) begin
                    if (rdy_i) begin
                        s_d.phase = PH_HIGH;
                        s_d.trig  = 1'b1;
                    end else begin
                        ovr_set_d = 1'b1;   // R4: generator still working
                    end
                end
            end
            PH_HIGH: begin
                s_d.phase = PH_LOW;
                ovr_set_d = req_i;          // R5: pulse in flight
            end
            PH_LOW: begin
                s_d.phase = PH_IDLE;
                ovr_set_d = req_i;          // R5: low cycle still pending
            end
            default: begin
                s_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{phase: PH_IDLE, trig: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign trig_o    = s_q.trig;
    assign ovr_set_o = ovr_set_d;

    // R2: the pulse is high for a single cycle.
    assert_pulse_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trig_o |=> !trig_o);

    // R2: after the pulse falls, it stays low for at least one more cycle.
    assert_low_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(trig_o) |=> !trig_o);

    // R3: a rising pulse needs a request with ready high one cycle before.
    assert_pulse_needs_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(trig_o) |-> $past(req_i && rdy_i));

    // R6: an idle, ready channel always takes its request.
    assert_idle_accepts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.phase == PH_IDLE && req_i && rdy_i) |=> trig_o);

endmodule

// File: rtl/trig_ovr_bank.sv
module trig_ovr_bank #(
    parameter int NUM_CH = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_CH-1:0] set_i,
    input  logic              clr_we_i,
    input  logic [NUM_CH-1:0] clr_mask_i,
    output logic [NUM_CH-1:0] flags_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] flag;
    } ovr_state_t;

    ovr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (clr_we_i && clr_mask_i[i]) begin
                st_d.flag[i] = 1'b0;
            end
            if (set_i[i]) begin
                st_d.flag[i] = 1'b1;        // R9: a set overrides a clear
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flag;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R8: a flag without a matching clear write stays set.
        assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flags_o[i] && !(clr_we_i && clr_mask_i[i])) |=> flags_o[i]);

        // R8: a clear write without a set in that cycle empties the flag.
        assert_clear_works_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_we_i && clr_mask_i[i] && !set_i[i]) |=> !flags_o[i]);

        // R9: a set always lands, even when it meets a clear.
        assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[i] |=> flags_o[i]);
    end

endmodule

// File: rtl/trig_dispatch.sv
module trig_dispatch
    import trig_dispatch_pkg::*;
#(
    parameter  int NUM_SRC = 2,
    parameter  int NUM_CH  = CH_COUNT,
    localparam int SEL_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_SRC-1:0]       evt_stb_i,
    input  logic [NUM_SRC*SEL_W-1:0] evt_sel_i,
    input  logic [NUM_CH-1:0]        gen_rdy_i,
    input  logic                     clr_we_i,
    input  logic [NUM_CH-1:0]        clr_mask_i,
    output logic [NUM_CH-1:0]        trig_o,
    output logic [NUM_CH-1:0]        ovr_o
);

    logic [NUM_CH-1:0] chan_req;
    logic [NUM_CH-1:0] ovr_set;

    trig_evt_route #(
        .NUM_SRC (NUM_SRC),
        .NUM_CH  (NUM_CH),
        .SEL_W   (SEL_W)
    ) u_route (
        .evt_stb_i  (evt_stb_i),
        .evt_sel_i  (evt_sel_i),
        .chan_req_o (chan_req)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        trig_chan_ctrl u_ctrl (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .req_i     (chan_req[c]),
            .rdy_i     (gen_rdy_i[c]),
            .trig_o    (trig_o[c]),
            .ovr_set_o (ovr_set[c])
        );

        // R4: a request meeting a low ready shows up as a flag one cycle later.
        assert_ready_low_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (chan_req[c] && !gen_rdy_i[c]) |=> ovr_o[c]);

        // R4: a request meeting a low ready never yields a pulse.
        assert_ready_low_no_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (chan_req[c] && !gen_rdy_i[c]) |=> !trig_o[c]);
    end

    trig_ovr_bank #(
        .NUM_CH (NUM_CH)
    ) u_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .set_i      (ovr_set),
        .clr_we_i   (clr_we_i),
        .clr_mask_i (clr_mask_i),
        .flags_o    (ovr_o)
    );

endmodule

// File: tb/trig_dispatch_test.sv
`timescale 1ns/1ps
module trig_dispatch_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] evt_stb = '0;
    logic [3:0] evt_sel = '0;
    logic [3:0] gen_rdy;
    logic       clr_we = 1'b0;
    logic [3:0] clr_mask = '0;
    logic [3:0] trig;
    logic [3:0] ovr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    trig_dispatch uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .evt_stb_i  (evt_stb),
        .evt_sel_i  (evt_sel),
        .gen_rdy_i  (gen_rdy),
        .clr_we_i   (clr_we),
        .clr_mask_i (clr_mask),
        .trig_o     (trig),
        .ovr_o      (ovr)
    );

    // Generator models: busy for a fixed number of cycles after each pulse.
    function automatic logic [5:0] busy_len(input int ch);
        case (ch)
            0: busy_len = 6'd20;   // ADC batch
            1: busy_len = 6'd3;
            2: busy_len = 6'd3;
            default: busy_len = 6'd5;
        endcase
    endfunction

    logic [5:0] busy_cnt [4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int ch = 0; ch < 4; ch++) busy_cnt[ch] <= '0;
        end else begin
            for (int ch = 0; ch < 4; ch++) begin
                if (trig[ch]) busy_cnt[ch] <= busy_len(ch);
                else if (busy_cnt[ch] != 0) busy_cnt[ch] <= busy_cnt[ch] - 6'd1;
            end
        end
    end

    always_comb begin
        for (int ch = 0; ch < 4; ch++) gen_rdy[ch] = (busy_cnt[ch] == 0);
    end

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a falling edge; return at the next falling edge.
    task automatic drive(input logic v0, input logic [1:0] c0,
                         input logic v1, input logic [1:0] c1,
                         input logic cwe, input logic [3:0] cmask);
        evt_stb  = {v1, v0};
        evt_sel  = {c1, c0};
        clr_we   = cwe;
        clr_mask = cmask;
        @(negedge clk);
        evt_stb  = '0;
        clr_we   = 1'b0;
        clr_mask = '0;
    endtask

    task automatic fire(input logic [1:0] ch);
        drive(1'b1, ch, 1'b0, 2'd0, 1'b0, 4'h0);
    endtask

    task automatic wait_idle();
        repeat (2) @(negedge clk);
        while (gen_rdy != 4'hF) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 trig in reset", trig, 4'h0);
        check("R1 ovr in reset", ovr, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 trig after reset", trig, 4'h0);
        check("R1 ovr after reset", ovr, 4'h0);
    endtask

    task automatic t_single();
        for (int ch = 0; ch < 4; ch++) begin
            fire(2'(ch));
            check("R2 pulse high", trig, 4'(1 << ch));
            @(negedge clk);
            check("R2 pulse low after one cycle", trig, 4'h0);
            check("R2 no overrun", ovr, 4'h0);
            wait_idle();
        end
    endtask

    task automatic t_ready_low();
        fire(2'd0);
        check("R2 adc pulse", trig, 4'b0001);
        repeat (3) @(negedge clk);
        fire(2'd0);
        check("R4 no pulse when ready low", trig, 4'h0);
        check("R4 flag set when ready low", ovr, 4'b0001);
        fire(2'd1);
        check("R6 timer pulse while adc busy", trig, 4'b0010);
        check("R6 other flags untouched", ovr, 4'b0001);
        wait_idle();
    endtask

    task automatic t_inflight();
        fire(2'd2);
        check("R2 timer B pulse", trig, 4'b0100);
        fire(2'd2);
        check("R5 dropped in flight", trig, 4'h0);
        check("R5 flag set in flight", ovr, 4'b0101);
        repeat (2) @(negedge clk);
        check("R5 no late pulse", trig, 4'h0);
        wait_idle();
    endtask

    task automatic t_clear();
        drive(1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 4'hF);
        check("R8 mask without write ignored", ovr, 4'b0101);
        drive(1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 4'b0001);
        check("R8 clear bit 0 only", ovr, 4'b0100);
        drive(1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 4'b1010);
        check("R8 other bits leave flag", ovr, 4'b0100);
        drive(1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 4'b0100);
        check("R8 clear bit 2", ovr, 4'b0000);
    endtask

    task automatic t_collide();
        fire(2'd3);
        check("R2 ext pulse", trig, 4'b1000);
        repeat (2) @(negedge clk);
        drive(1'b1, 2'd3, 1'b0, 2'd0, 1'b1, 4'b1000);
        check("R9 set wins over clear", ovr, 4'b1000);
        drive(1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 4'b1000);
        check("R8 later clear", ovr, 4'b0000);
        wait_idle();
    endtask

    task automatic t_dual();
        drive(1'b1, 2'd1, 1'b1, 2'd2, 1'b0, 4'h0);
        check("R7 two channels same cycle", trig, 4'b0110);
        wait_idle();
        drive(1'b1, 2'd3, 1'b1, 2'd3, 1'b0, 4'h0);
        check("R7 same channel merged", trig, 4'b1000);
        check("R7 merged no overrun", ovr, 4'b0000);
        wait_idle();
        fire(2'd0);
        repeat (3) @(negedge clk);
        drive(1'b1, 2'd0, 1'b1, 2'd3, 1'b0, 4'h0);
        check("R6 idle channel proceeds", trig, 4'b1000);
        check("R6 busy channel flagged", ovr, 4'b0001);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_single();
        t_ready_low();
        t_inflight();
        t_clear();
        t_collide();
        t_dual();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule